// File: doc/BRIEF.md
# Instruction Fetch and Address Unit

This block keeps the program counter and the instruction register for a multi-cycle processor in which one memory holds both the program and its data. A single select input picks the memory address. It is either the program counter, for an instruction fetch, or a data address taken from the datapath's A bus, for a load or a store. Each cycle the microcode decides whether the word read from memory goes into the instruction register, whether the program counter steps by one, and whether it jumps by a signed offset.

The instruction register drives its fields onto separate outputs. The rest of the datapath uses these outputs, and the microsequencer uses the opcode to branch to that instruction's microprogram. The jump offset is a 10-bit immediate built from the destination field (upper half) and the second source field (lower half). It is sign-extended to the address width before it is added to the current program counter.

Top module: `ifetch_addr_unit`

## Requirements
- R1: While `addr_sel` is 0, `mem_addr` equals `pc_q` in the same cycle.
- R2: While `addr_sel` is 1, `mem_addr` equals `bus_a` in the same cycle.
- R3: When `ir_load` is 1 at a rising clock edge, `ir_q` holds the `mem_rdata` value sampled at that edge from the following cycle on.
- R4: When `ir_load` is 0 at an edge, `ir_q` keeps its value.
- R5: When `pc_inc` is 1 and `pc_jump` is 0 at an edge, `pc_q` becomes `pc_q + 1` (modulo 2^32).
- R6: When `pc_jump` is 1 at an edge, `pc_q` becomes `pc_q` plus the sign extension of the 10-bit value {ir_q[14:10], ir_q[4:0]}, whose bit 9 (ir_q[14]) is the sign.
- R7: When `pc_inc` and `pc_jump` are both 1, the jump of R6 is taken and the increment is dropped.
- R8: When neither `pc_inc` nor `pc_jump` is 1 at an edge, `pc_q` keeps its value.
- R9: `opcode` shows ir_q[31:15], `dst_f` shows ir_q[14:10], `srca_f` shows ir_q[9:5] and `srcb_f` shows ir_q[4:0].
- R10: A synchronous active-high `rst` sets `pc_q` and `ir_q` to zero on the next edge and overrides every other control input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 A bus |
| bus_a | input | 32 | Data address from the datapath A bus |
| mem_rdata | input | 32 | Word read from the shared memory |
| ir_load | input | 1 | Load the instruction register from `mem_rdata` |
| pc_inc | input | 1 | Step the program counter by one |
| pc_jump | input | 1 | Add the sign-extended immediate to the program counter |
| mem_addr | output | 32 | Address presented to the shared memory |
| pc_q | output | 32 | Current program counter |
| ir_q | output | 32 | Current instruction register |
| opcode | output | 17 | Opcode field for the microsequencer |
| dst_f | output | 5 | Destination register field |
| srca_f | output | 5 | First source register field |
| srcb_f | output | 5 | Second source register field |

## Verification
The checker tests several rules on every clock edge: the address mux choice, the way the instruction register loads and holds, the update of the program counter for step, jump, both together and neither, and the reset values. The field split and the exact arithmetic of a backward jump only show up through the bench scenarios. These scenarios load known words from a modelled memory and check the decoded fields. They also check the program counter after forward and backward jumps, including a jump issued in the same cycle as a step request.

// File: rtl/ifau_pkg.sv
package ifau_pkg;
   typedef enum logic {
      ADDR_PC  = 1'b0,
      ADDR_BUS = 1'b1
   } addr_src_e;

   typedef enum logic [1:0] {
      PC_HOLD = 2'd0,
      PC_STEP = 2'd1,
      PC_JUMP = 2'd2
   } pc_act_e;
endpackage

// File: rtl/ifau_addr_mux.sv
module ifau_addr_mux
   import ifau_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          sel,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] bus,
   output logic [AW-1:0] addr
);
   always_comb begin
      if (sel == ADDR_BUS) addr = bus;
      else                 addr = pc;
   end
endmodule

// File: rtl/ifau_pc_ctl.sv
module ifau_pc_ctl
   import ifau_pkg::*;
#(
   parameter int AW          = 32,
   parameter int IMM_W       = 10,
   parameter bit SEXT_OFFSET = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic             jump,
   input  logic [IMM_W-1:0] imm,
   output logic [AW-1:0]    pc
);
   localparam int PAD_W = AW - IMM_W;

   logic [AW-1:0] offset;
   pc_act_e       act;

   generate
      if (SEXT_OFFSET) begin : g_signed
         assign offset = {{PAD_W{imm[IMM_W-1]}}, imm};
      end else begin : g_unsigned
         assign offset = {{PAD_W{1'b0}}, imm};
      end
   endgenerate

   always_comb begin
      if (jump)     act = PC_JUMP;
      else if (inc) act = PC_STEP;
      else          act = PC_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else begin
         case (act)
            PC_JUMP: pc <= pc + offset;
            PC_STEP: pc <= pc + AW'(1);
            default: pc <= pc;
         endcase
      end
   end
endmodule

// File: rtl/ifau_ir_reg.sv
module ifau_ir_reg #(
   parameter int DW    = 32,
   parameter int OPC_W = 17,
   parameter int FLD_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    ir,
   output logic [OPC_W-1:0] opc,
   output logic [FLD_W-1:0] fld_d,
   output logic [FLD_W-1:0] fld_a,
   output logic [FLD_W-1:0] fld_b
);
   localparam int B_LO = 0;
   localparam int A_LO = FLD_W;
   localparam int D_LO = 2 * FLD_W;
   localparam int O_LO = 3 * FLD_W;

   always_ff @(posedge clk) begin
      if (rst)       ir <= '0;
      else if (load) ir <= din;
   end

   assign opc   = ir[O_LO +: OPC_W];
   assign fld_d = ir[D_LO +: FLD_W];
   assign fld_a = ir[A_LO +: FLD_W];
   assign fld_b = ir[B_LO +: FLD_W];
endmodule

// File: rtl/ifetch_addr_unit.sv
module ifetch_addr_unit #(
   parameter int DATA_W      = 32,
   parameter int OPC_W       = 17,
   parameter int FLD_W       = 5,
   parameter bit SEXT_OFFSET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_sel,
   input  logic [DATA_W-1:0] bus_a,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              ir_load,
   input  logic              pc_inc,
   input  logic              pc_jump,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] pc_q,
   output logic [DATA_W-1:0] ir_q,
   output logic [OPC_W-1:0]  opcode,
   output logic [FLD_W-1:0]  dst_f,
   output logic [FLD_W-1:0]  srca_f,
   output logic [FLD_W-1:0]  srcb_f
);
   localparam int IMM_W = 2 * FLD_W;

   initial begin
      assert (OPC_W + 3 * FLD_W == DATA_W)
         else $fatal(1, "opcode plus three fields must fill the word");
      assert (IMM_W < DATA_W)
         else $fatal(1, "immediate must be narrower than the address");
   end

   logic [IMM_W-1:0] imm;
   assign imm = {dst_f, srcb_f};

   ifau_addr_mux #(.AW(DATA_W)) u_mux (
      .sel  (addr_sel),
      .pc   (pc_q),
      .bus  (bus_a),
      .addr (mem_addr)
   );

   ifau_pc_ctl #(
      .AW          (DATA_W),
      .IMM_W       (IMM_W),
      .SEXT_OFFSET (SEXT_OFFSET)
   ) u_pc (
      .clk  (clk),
      .rst  (rst),
      .inc  (pc_inc),
      .jump (pc_jump),
      .imm  (imm),
      .pc   (pc_q)
   );

   ifau_ir_reg #(
      .DW    (DATA_W),
      .OPC_W (OPC_W),
      .FLD_W (FLD_W)
   ) u_ir (
      .clk   (clk),
      .rst   (rst),
      .load  (ir_load),
      .din   (mem_rdata),
      .ir    (ir_q),
      .opc   (opcode),
      .fld_d (dst_f),
      .fld_a (srca_f),
      .fld_b (srcb_f)
   );
endmodule

// File: rtl/ifau_chk.sv
module ifau_chk #(
   parameter int DATA_W = 32,
   parameter int FLD_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              addr_sel,
   input logic [DATA_W-1:0] bus_a,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              ir_load,
   input logic              pc_inc,
   input logic              pc_jump,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] pc_q,
   input logic [DATA_W-1:0] ir_q
);
   localparam int IMM_W = 2 * FLD_W;

   function automatic logic [DATA_W-1:0] jump_ofs(input logic [DATA_W-1:0] w);
      logic [IMM_W-1:0] im;
      im = {w[2*FLD_W +: FLD_W], w[0 +: FLD_W]};
      return {{(DATA_W-IMM_W){im[IMM_W-1]}}, im};
   endfunction

   a_r1_addr_pc: assert property (@(posedge clk) disable iff (rst)
      !addr_sel |-> mem_addr == pc_q);

   a_r2_addr_bus: assert property (@(posedge clk) disable iff (rst)
      addr_sel |-> mem_addr == bus_a);

   a_r3_ir_load: assert property (@(posedge clk) disable iff (rst)
      ir_load |=> ir_q == $past(mem_rdata));

   a_r4_ir_hold: assert property (@(posedge clk) disable iff (rst)
      !ir_load |=> $stable(ir_q));

   a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
      (pc_inc && !pc_jump) |=> pc_q == $past(pc_q) + DATA_W'(1));

   a_r6_pc_jump: assert property (@(posedge clk) disable iff (rst)
      pc_jump |=> pc_q == $past(pc_q) + jump_ofs($past(ir_q)));

   a_r7_jump_wins: assert property (@(posedge clk) disable iff (rst)
      (pc_jump && pc_inc) |=> pc_q != $past(pc_q) + DATA_W'(1) ||
                              jump_ofs($past(ir_q)) == DATA_W'(1));

   a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
      (!pc_inc && !pc_jump) |=> $stable(pc_q));

   a_r10_reset: assert property (@(posedge clk)
      rst |=> (pc_q == '0 && ir_q == '0));
endmodule

bind ifetch_addr_unit ifau_chk #(
   .DATA_W (DATA_W),
   .FLD_W  (FLD_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .addr_sel  (addr_sel),
   .bus_a     (bus_a),
   .mem_rdata (mem_rdata),
   .ir_load   (ir_load),
   .pc_inc    (pc_inc),
   .pc_jump   (pc_jump),
   .mem_addr  (mem_addr),
   .pc_q      (pc_q),
   .ir_q      (ir_q)
);

// File: tb/ifetch_addr_unit_test.sv
`timescale 1ns/1ps
module ifetch_addr_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        addr_sel = 1'b0;
   logic [31:0] bus_a = '0;
   logic [31:0] mem_rdata;
   logic        ir_load = 1'b0;
   logic        pc_inc = 1'b0;
   logic        pc_jump = 1'b0;
   logic [31:0] mem_addr, pc_q, ir_q;
   logic [16:0] opcode;
   logic [4:0]  dst_f, srca_f, srcb_f;

   logic [31:0] mem [64];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always_comb mem_rdata = mem[mem_addr[5:0]];

   ifetch_addr_unit uut (
      .clk(clk), .rst(rst), .addr_sel(addr_sel), .bus_a(bus_a),
      .mem_rdata(mem_rdata), .ir_load(ir_load), .pc_inc(pc_inc),
      .pc_jump(pc_jump), .mem_addr(mem_addr), .pc_q(pc_q), .ir_q(ir_q),
      .opcode(opcode), .dst_f(dst_f), .srca_f(srca_f), .srcb_f(srcb_f)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic drive(input logic sel, input logic ld, input logic inc, input logic jmp);
      addr_sel = sel; ir_load = ld; pc_inc = inc; pc_jump = jmp;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      drive(1'b0, 1'b1, 1'b1, 1'b1);
      tick(); tick();
      check("R10 pc after reset", pc_q, 32'h0);
      check("R10 ir after reset", ir_q, 32'h0);
      rst = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_addr_mux();
      bus_a = 32'h1234_5678;
      addr_sel = 1'b0; #1;
      check("R1 address from pc", mem_addr, pc_q);
      addr_sel = 1'b1; #1;
      check("R2 address from bus", mem_addr, 32'h1234_5678);
      addr_sel = 1'b0; #1;
   endtask

   task automatic t_fetch();
      drive(1'b0, 1'b1, 1'b1, 1'b0);
      tick();
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check("R3 ir loaded", ir_q, mem[0]);
      check("R5 pc stepped", pc_q, 32'd1);
      check("R9 opcode", {15'h0, opcode}, 32'h1ABCD);
      check("R9 dst", {27'h0, dst_f}, 32'd3);
      check("R9 srca", {27'h0, srca_f}, 32'd7);
      check("R9 srcb", {27'h0, srcb_f}, 32'd1);
   endtask

   task automatic t_hold();
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      bus_a = 32'h0000_0022;
      tick(); tick();
      check("R4 ir held", ir_q, mem[0]);
      check("R8 pc held", pc_q, 32'd1);
      addr_sel = 1'b0;
   endtask

   task automatic t_jump_fwd();
      drive(1'b0, 1'b0, 1'b0, 1'b1);
      tick();
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check("R6 forward jump", pc_q, 32'd98);
   endtask

   task automatic t_jump_back();
      drive(1'b0, 1'b1, 1'b0, 1'b0);
      tick();
      check("R3 ir second load", ir_q, mem[34]);
      drive(1'b0, 1'b0, 1'b0, 1'b1);
      tick();
      check("R6 backward jump", pc_q, 32'd96);
      drive(1'b0, 1'b0, 1'b1, 1'b1);
      tick();
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check("R7 jump beats step", pc_q, 32'd94);
   endtask

   task automatic t_reset_mid();
      rst = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 1'b1);
      tick();
      check("R10 mid-run pc", pc_q, 32'h0);
      check("R10 mid-run ir", ir_q, 32'h0);
      rst = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 + i;
      mem[0]  = {17'h1ABCD, 5'd3, 5'd7, 5'd1};
      mem[34] = {17'h00005, 5'b11111, 5'd0, 5'b11110};
      t_reset();
      t_addr_mux();
      t_fetch();
      t_hold();
      t_jump_fwd();
      t_jump_back();
      t_reset_mid();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule